// File: doc/BRIEF.md
# Interrupt Recognition Gating Unit

This block sits beside the execution unit of a simple in-order processor core and decides, on every clock, whether one pending interrupt may be taken. The execution unit pulses `boundary` in the cycle an instruction retires. With that pulse it supplies decode flags for the retiring instruction: a segment-register load, a boundary between iterations of a repeated string operation, or a wait-for-coprocessor instruction. The gate combines these flags with the interrupt-enable flag, the bus-hold state and the coprocessor-busy state. It then arbitrates between a latched software interrupt or exception, a latched non-maskable request and a level-sensitive maskable request.

When a source is taken, the gate pulses `accept` for one cycle. Alongside it the gate presents the 8-bit vector type, whether the hardware status bits should be updated, and two flags that tell the core how to build the return point. The type and flags stay on the outputs until the next accept. No further accept is possible until the core signals `ack` to say the vector fetch has been issued.

Top module: `irq_recog_gate`

## Requirements
- R1: `accept` rises only in the cycle after a cycle with `boundary` high, and is a single-cycle pulse.
- R2: A maskable request (`mReq`) is taken only if `ie` is 1 in the boundary cycle. `mReq` is level-sensitive and is looked at only in boundary cycles, so a request that drops before a boundary is never taken.
- R3: While `holdAct` is 1, no source of any kind is accepted at a boundary.
- R4: While `copBusy` is 1, no source of any kind is accepted at a boundary.
- R5: A boundary whose retiring instruction has `segLoad` = 1 is not valid. Pending sources are taken at the next boundary instead, provided that boundary is otherwise valid.
- R6: `repIter` marks a valid boundary. When a source is accepted there, `prefixRestore` is 1 with the accept.
- R7: `waitInstr` marks an interruptible boundary. When a source is accepted there, `restartSame` is 1 with the accept.
- R8: A software interrupt or exception (`swEvt` with `swType`) is accepted with `vecType` = `swType` and `hwStatusUpd` = 0. This holds even when `swType` equals the non-maskable type 2. A non-maskable accept gives `vecType` = 2 and `hwStatusUpd` = 1. A maskable accept gives `vecType` = `mType` and `hwStatusUpd` = 1.
- R9: When several sources are eligible at one valid boundary, software/exception wins over non-maskable, and non-maskable wins over maskable. Losing sources stay pending.
- R10: The non-maskable input is detected on its rising edge and stays pending until accepted. Holding it high afterwards does not cause a second accept.
- R11: After an accept, `vecType`, `hwStatusUpd`, `prefixRestore` and `restartSame` hold until the next accept. Boundaries are not valid until the cycle after the one in which `ack` is high.
- R12: After reset all outputs are 0 and no source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| boundary | input | 1 | Instruction retires this cycle |
| segLoad | input | 1 | Retiring instruction loads a segment register |
| repIter | input | 1 | Boundary lies between repeated string iterations |
| waitInstr | input | 1 | Retiring point is a wait-for-coprocessor instruction |
| ie | input | 1 | Interrupt-enable flag |
| holdAct | input | 1 | Bus granted to an external master |
| copBusy | input | 1 | Coprocessor numeric instruction in progress |
| mReq | input | 1 | Maskable request level |
| mType | input | 8 | Vector type of the maskable request |
| nmiIn | input | 1 | Non-maskable request input |
| swEvt | input | 1 | Software interrupt or exception event pulse |
| swType | input | 8 | Type carried by the software event |
| ack | input | 1 | Core has issued the vector fetch |
| accept | output | 1 | One-cycle accept pulse |
| vecType | output | 8 | Selected vector type |
| hwStatusUpd | output | 1 | Hardware status bits should be updated |
| prefixRestore | output | 1 | Restore only the prefix before the string primitive |
| restartSame | output | 1 | Return to the interrupted instruction itself |

## Verification
The assertions check on every cycle that an accept comes only from a boundary with no hold, no busy coprocessor and no segment load. They also check that the return-point flags match the decode flags of that boundary, that the accept is a single pulse, and that the vector type does not move between accepts. Some behaviours need the bench's scenarios because they depend on history or arbitration, not on one cycle: the one-boundary deferral that releases at the following boundary, the priority order with losers staying pending, single capture of a held non-maskable level, the ack window, and a software interrupt reusing type 2 without a status update.

// File: rtl/irg_pkg.sv
`timescale 1ns/1ps
package irg_pkg;
  // Strobes from the control decision to the type/flag datapath
  typedef struct packed {
    logic fire;
    logic takeSw;
    logic takeNmi;
    logic takeMask;
  } takeStrb_t;
endpackage

// File: rtl/irg_ctrl.sv
`timescale 1ns/1ps
module irg_ctrl
  import irg_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      boundary,
  input  logic      segLoad,
  input  logic      holdAct,
  input  logic      copBusy,
  input  logic      ie,
  input  logic      mReq,
  input  logic      nmiIn,
  input  logic      swEvt,
  input  logic      ack,
  output takeStrb_t strb,
  output logic      accept
);
  logic nmiPrev;
  logic nmiPend;
  logic swPend;
  logic inFlight;
  logic validBnd;
  logic maskOk;

  // A boundary counts only if nothing defers or blocks recognition
  assign validBnd = boundary & ~segLoad & ~holdAct & ~copBusy & ~inFlight;
  assign maskOk   = mReq & ie;

  always_comb begin
    strb.takeSw   = validBnd & swPend;
    strb.takeNmi  = validBnd & ~swPend & nmiPend;
    strb.takeMask = validBnd & ~swPend & ~nmiPend & maskOk;
    strb.fire     = strb.takeSw | strb.takeNmi | strb.takeMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiPrev  <= 1'b0;
      nmiPend  <= 1'b0;
      swPend   <= 1'b0;
      inFlight <= 1'b0;
      accept   <= 1'b0;
    end else begin
      nmiPrev  <= nmiIn;
      nmiPend  <= (nmiIn & ~nmiPrev) | (nmiPend & ~strb.takeNmi);
      swPend   <= swEvt | (swPend & ~strb.takeSw);
      inFlight <= strb.fire | (inFlight & ~ack);
      accept   <= strb.fire;
    end
  end
endmodule

// File: rtl/irg_dp.sv
`timescale 1ns/1ps
module irg_dp
  import irg_pkg::*;
#(
  parameter int TYPE_W   = 8,
  parameter int NMI_TYPE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  takeStrb_t         strb,
  input  logic              swEvt,
  input  logic [TYPE_W-1:0] swType,
  input  logic [TYPE_W-1:0] mType,
  input  logic              repIter,
  input  logic              waitInstr,
  output logic [TYPE_W-1:0] vecType,
  output logic              hwStatusUpd,
  output logic              prefixRestore,
  output logic              restartSame
);
  localparam logic [TYPE_W-1:0] NmiVec = TYPE_W'(NMI_TYPE);

  logic [TYPE_W-1:0] swTypeQ;
  logic [TYPE_W-1:0] selType;

  always_comb begin
    if (strb.takeSw)       selType = swTypeQ;
    else if (strb.takeNmi) selType = NmiVec;
    else                   selType = mType;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swTypeQ       <= '0;
      vecType       <= '0;
      hwStatusUpd   <= 1'b0;
      prefixRestore <= 1'b0;
      restartSame   <= 1'b0;
    end else begin
      if (swEvt) swTypeQ <= swType;
      if (strb.fire) begin
        vecType       <= selType;
        hwStatusUpd   <= ~strb.takeSw;   // software never touches hw status
        prefixRestore <= repIter;
        restartSame   <= waitInstr;
      end
    end
  end
endmodule

// File: rtl/irq_recog_gate.sv
`timescale 1ns/1ps
module irq_recog_gate
  import irg_pkg::*;
#(
  parameter int TYPE_W   = 8,
  parameter int NMI_TYPE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              boundary,
  input  logic              segLoad,
  input  logic              repIter,
  input  logic              waitInstr,
  input  logic              ie,
  input  logic              holdAct,
  input  logic              copBusy,
  input  logic              mReq,
  input  logic [TYPE_W-1:0] mType,
  input  logic              nmiIn,
  input  logic              swEvt,
  input  logic [TYPE_W-1:0] swType,
  input  logic              ack,
  output logic              accept,
  output logic [TYPE_W-1:0] vecType,
  output logic              hwStatusUpd,
  output logic              prefixRestore,
  output logic              restartSame
);
  takeStrb_t strb;

  irg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .boundary(boundary), .segLoad(segLoad),
    .holdAct(holdAct), .copBusy(copBusy), .ie(ie), .mReq(mReq),
    .nmiIn(nmiIn), .swEvt(swEvt), .ack(ack), .strb(strb), .accept(accept)
  );

  irg_dp #(.TYPE_W(TYPE_W), .NMI_TYPE(NMI_TYPE)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .swEvt(swEvt), .swType(swType),
    .mType(mType), .repIter(repIter), .waitInstr(waitInstr),
    .vecType(vecType), .hwStatusUpd(hwStatusUpd),
    .prefixRestore(prefixRestore), .restartSame(restartSame)
  );
endmodule

// File: rtl/irg_checker.sv
`timescale 1ns/1ps
module irg_checker #(
  parameter int TYPE_W   = 8,
  parameter int NMI_TYPE = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              boundary,
  input logic              segLoad,
  input logic              repIter,
  input logic              waitInstr,
  input logic              ie,
  input logic              holdAct,
  input logic              copBusy,
  input logic              accept,
  input logic [TYPE_W-1:0] vecType,
  input logic              hwStatusUpd,
  input logic              prefixRestore,
  input logic              restartSame
);
  AST_ACCEPT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> $past(boundary)); // R1
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !accept); // R1
  AST_MASK_NEEDS_IE: assert property (@(posedge clk) disable iff (!rstN)
    (accept && hwStatusUpd && vecType != TYPE_W'(NMI_TYPE)) |-> $past(ie)); // R2
  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> !$past(holdAct)); // R3
  AST_COP_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> !$past(copBusy)); // R4
  AST_SEGLOAD_DEFERS: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> !$past(segLoad)); // R5
  AST_PREFIX_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> (prefixRestore == $past(repIter))); // R6
  AST_RESTART_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> (restartSame == $past(waitInstr))); // R7
  AST_TYPE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !accept |-> $stable(vecType)); // R11
endmodule

bind irq_recog_gate irg_checker #(.TYPE_W(TYPE_W), .NMI_TYPE(NMI_TYPE)) uChk (
  .clk(clk), .rstN(rstN), .boundary(boundary), .segLoad(segLoad),
  .repIter(repIter), .waitInstr(waitInstr), .ie(ie), .holdAct(holdAct),
  .copBusy(copBusy), .accept(accept), .vecType(vecType),
  .hwStatusUpd(hwStatusUpd), .prefixRestore(prefixRestore),
  .restartSame(restartSame)
);

// File: tb/tb_irq_recog_gate.sv
`timescale 1ns/1ps
module tb_irq_recog_gate;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic rstN = 1'b0;
  logic boundary = 0, segLoad = 0, repIter = 0, waitInstr = 0;
  logic ie = 0, holdAct = 0, copBusy = 0, mReq = 0, nmiIn = 0;
  logic swEvt = 0, ack = 0;
  logic [7:0] mType = 8'h20, swType = 8'h00;
  logic accept, hwStatusUpd, prefixRestore, restartSame;
  logic [7:0] vecType;

  irq_recog_gate dut (
    .clk(clk), .rstN(rstN), .boundary(boundary), .segLoad(segLoad),
    .repIter(repIter), .waitInstr(waitInstr), .ie(ie), .holdAct(holdAct),
    .copBusy(copBusy), .mReq(mReq), .mType(mType), .nmiIn(nmiIn),
    .swEvt(swEvt), .swType(swType), .ack(ack), .accept(accept),
    .vecType(vecType), .hwStatusUpd(hwStatusUpd),
    .prefixRestore(prefixRestore), .restartSame(restartSame)
  );

  int vectors = 0, miscompares = 0, cycles = 0;
  bit done = 0;
  string curReq = "R12";

  // Behavioural reference state
  bit nPend = 0, sPend = 0, busyAck = 0, nPrev = 0;
  int sType = 0;
  bit eAcc = 0, eHw = 0, ePre = 0, eRst = 0;
  int eType = 0;
  bit okBnd;
  int pick;  // 0 none, 1 software, 2 non-maskable, 3 maskable
  int acceptCount = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      nPend = 0; sPend = 0; busyAck = 0; nPrev = 0; sType = 0;
      eAcc = 0; eHw = 0; ePre = 0; eRst = 0; eType = 0;
    end else begin
      okBnd = boundary && !segLoad && !holdAct && !copBusy && !busyAck;
      pick = 0;
      if (okBnd) begin
        if (sPend) pick = 1;
        else if (nPend) pick = 2;
        else if (mReq && ie) pick = 3;
      end
      eAcc = (pick != 0);
      if (pick != 0) begin
        eType = (pick == 1) ? sType : (pick == 2) ? 2 : int'(mType);
        eHw = (pick != 1);
        ePre = repIter;
        eRst = waitInstr;
      end
      if (nmiIn && !nPrev) nPend = 1; else if (pick == 2) nPend = 0;
      nPrev = nmiIn;
      if (swEvt) begin sPend = 1; sType = int'(swType); end
      else if (pick == 1) sPend = 0;
      if (pick != 0) busyAck = 1; else if (ack) busyAck = 0;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (accept) acceptCount++;
      if (accept !== eAcc) begin
        miscompares++;
        $display("FAIL %s/R1 accept act=%0b exp=%0b", curReq, accept, eAcc);
      end
      if (int'(vecType) != eType || $isunknown(vecType)) begin
        miscompares++;
        $display("FAIL %s/R8 vecType act=%0d exp=%0d", curReq, vecType, eType);
      end
      if (hwStatusUpd !== eHw) begin
        miscompares++;
        $display("FAIL %s/R8 hwStatusUpd act=%0b exp=%0b", curReq, hwStatusUpd, eHw);
      end
      if (prefixRestore !== ePre) begin
        miscompares++;
        $display("FAIL %s/R6 prefixRestore act=%0b exp=%0b", curReq, prefixRestore, ePre);
      end
      if (restartSame !== eRst) begin
        miscompares++;
        $display("FAIL %s/R7 restartSame act=%0b exp=%0b", curReq, restartSame, eRst);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic bnd(input logic sl, input logic rp, input logic wt);
    boundary = 1; segLoad = sl; repIter = rp; waitInstr = wt;
    tick();
    boundary = 0; segLoad = 0; repIter = 0; waitInstr = 0;
    tick();
  endtask

  task automatic doAck();
    ack = 1; tick(); ack = 0; tick();
  endtask

  task automatic swIrq(input logic [7:0] t);
    swEvt = 1; swType = t; tick(); swEvt = 0;
  endtask

  task automatic expectCount(input string req, input int want);
    vectors++;
    if (acceptCount != want) begin
      miscompares++;
      $display("FAIL %s accept count act=%0d exp=%0d", req, acceptCount, want);
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      miscompares++;
      $display("FAIL watchdog act=%0d cycles exp=<20000", cycles);
      finishRun();
    end
  end

  initial begin
    curReq = "R12";
    repeat (4) tick();
    rstN = 1; tick(); tick();
    expectCount("R12", 0);

    curReq = "R2";      // disabled maskable ignored, then taken
    mReq = 1; ie = 0; bnd(0, 0, 0);
    expectCount("R2", 0);
    ie = 1; bnd(0, 0, 0); doAck();
    expectCount("R2", 1);
    mReq = 0; tick();
    mReq = 1; tick(); mReq = 0; tick();   // pulse between boundaries
    bnd(0, 0, 0);
    expectCount("R2", 1);

    curReq = "R3";      // hold blocks a fresh non-maskable edge
    nmiIn = 1; tick(); nmiIn = 0;
    holdAct = 1; bnd(0, 0, 0); holdAct = 0;
    expectCount("R3", 1);
    curReq = "R10";
    bnd(0, 0, 0); doAck();
    expectCount("R10", 2);

    curReq = "R4";
    mReq = 1; copBusy = 1; bnd(0, 0, 0); copBusy = 0;
    expectCount("R4", 2);

    curReq = "R5";      // segment load boundary deferred by one
    bnd(1, 0, 0);
    expectCount("R5", 2);
    bnd(0, 0, 0); doAck();
    expectCount("R5", 3);

    curReq = "R6";
    bnd(0, 1, 0); doAck();
    curReq = "R7";
    bnd(0, 0, 1); doAck();
    mReq = 0;

    curReq = "R9";      // all three eligible: sw (type 2), then nmi, then mask
    swIrq(8'd2); nmiIn = 1; mReq = 1; mType = 8'h41; tick();
    bnd(0, 0, 0); doAck();
    curReq = "R8";
    bnd(0, 0, 0); doAck();
    curReq = "R9";
    bnd(0, 0, 0); doAck();
    expectCount("R9", 8);

    curReq = "R10";     // nmiIn still high: no second accept
    mReq = 0; bnd(0, 0, 0);
    expectCount("R10", 8);
    nmiIn = 0;

    curReq = "R11";     // no accept without ack, nor in the ack cycle
    swIrq(8'h7f); tick();
    bnd(0, 0, 0);
    swIrq(8'h33); tick();
    bnd(0, 0, 0);
    expectCount("R11", 9);
    boundary = 1; ack = 1; tick(); boundary = 0; ack = 0; tick();
    expectCount("R11", 9);
    bnd(0, 0, 0); doAck();
    expectCount("R11", 10);

    curReq = "R1";
    repeat (3) tick();
    finishRun();
  end
endmodule